// File: doc/BRIEF.md
# I2C Serial EEPROM Target Engine

This block is the bus-side protocol engine of a 4 KB serial EEPROM that answers as a target on a two-wire I2C bus. It samples the SCL and SDA lines with the system clock. It drives SDA only by pulling it low. It recognises START and STOP, decodes the select byte, and takes in a two-byte address. It then performs byte writes, page writes, random reads, current-address reads and sequential reads against an internal byte array.

Writes are collected in a one-page buffer. The buffer is committed to the array during an internal write cycle, which is modelled as a busy timer of `WRITE_CYCLES` clocks. While that timer runs, the engine ignores the bus completely, so a master can poll with its select byte until an ACK comes back. A write-protect input blocks data bytes but still lets the select and address bytes through.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The select byte is taken MSB first. Bits [7:4] must equal 1010 and bits [3:1] must equal `chip_en_i`. Bit [0] selects the direction (1 = read). On a mismatch there is no ACK and SDA stays released until the next START. Out of reset, SDA is released.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bits are taken on SCL rising edges. An ACK is SDA held low by the engine through the 9th SCL clock of a byte. The engine only starts pulling SDA while SCL is low.
- R3: A write is the select byte with bit 0 = 0, then the address high byte, then the address low byte, then data. Each of these bytes is ACKed.
- R4: A page write accepts 1 to 32 bytes. Address bits [11:5] fix the page. The 5-bit in-page offset advances after each byte and wraps from 31 to 0 within the same page.
- R5: The write cycle starts only when STOP comes in the clock that directly follows a data byte's ACK. A STOP partway through a byte, or a repeated START, writes nothing and does not make the engine busy.
- R6: For `WRITE_CYCLES` clocks after a valid write STOP, the engine gives no ACK, even to its own select byte. After that it ACKs again.
- R7: While `wp_i` is high, the select and address bytes are ACKed, every data byte is NACKed, no write cycle starts, and the array is unchanged.
- R8: After a completed write, the address counter holds the in-page location that follows the last byte written.
- R9: Only address bits [11:0] are used. Bits [7:4] of the address high byte are ignored.
- R10: A random read is a write header that loads the address, then a repeated START, then a select byte with bit 0 = 1. A current-address read is a read select with no header. Either read returns the byte at the counter.
- R11: A sequential read advances the counter after each byte across the whole array, wrapping from 0xFFF to 0x000. A master NACK in the 9th clock ends the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| chip_en_i | input | 3 | Strapped chip-enable value compared with select bits [3:1] |
| wp_i | input | 1 | Write protect; high blocks all data writes |
| sda_pull_o | output | 1 | High to pull SDA low (open-drain enable) |

## Verification
The assertions assume two things about the bus. First, each SCL high and low phase lasts several system clocks, long enough for the two-flop synchronizer and the edge detector to see it. Second, the master changes SDA only while SCL is low, except when it makes a START or STOP. Under these assumptions, a pull on SDA can only begin in a low phase, the engine is silent whenever it is idle or busy, and the page bits stay fixed through a write. The stimulus drives every SCL phase as two quarter periods of five clocks each. It moves SDA only in the middle of the low phase, and it waits out the full write cycle before checking the ready state of a write. It also issues deliberate polls during the busy time to observe the silence.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int          ADDR_W       = 12,
  parameter int          PAGE_W       = 5,
  parameter int          WRITE_CYCLES = 2000,
  parameter logic [3:0]  TYPE_ID      = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_en_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD} st_t;

  st_t               st, nxt;
  logic [2:0]        scl_sy, sda_sy;
  logic [3:0]        bitcnt;
  logic [6:0]        shreg, txreg;
  logic [ADDR_W-1:0] addr;
  logic              ack_drv, armed, busy;
  logic [TW-1:0]     wtimer;
  logic [PAGE-1:0]   pmask;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE];
  logic [7:0]        rd_q;

  logic scl_s, scl_q, sda_s, sda_q;
  assign scl_s = scl_sy[1];
  assign scl_q = scl_sy[2];
  assign sda_s = sda_sy[1];
  assign sda_q = sda_sy[2];

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  logic [7:0] rx_byte;
  assign rx_byte = {shreg, sda_s};

  logic buf_we;
  assign buf_we = !busy && !start_det && !stop_det && scl_rise &&
                  st == S_WR && bitcnt == 4'd7 && !wp_i;

  logic [PAGE_W-1:0] widx;
  logic              mem_we;
  assign widx   = wtimer[PAGE_W-1:0];
  assign mem_we = busy && (wtimer < TW'(PAGE)) && pmask[widx];

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[addr[PAGE_W-1:0]] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[{addr[ADDR_W-1:PAGE_W], widx}] <= pbuf[widx];
    rd_q <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy     <= '1;
      sda_sy     <= '1;
      st         <= S_IDLE;
      nxt        <= S_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      txreg      <= '0;
      addr       <= '0;
      ack_drv    <= 1'b0;
      armed      <= 1'b0;
      busy       <= 1'b0;
      wtimer     <= '0;
      pmask      <= '0;
      sda_pull_o <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
      if (busy) begin
        st         <= S_IDLE;
        sda_pull_o <= 1'b0;
        if (wtimer == TW'(WRITE_CYCLES - 1)) begin
          busy  <= 1'b0;
          pmask <= '0;
        end else begin
          wtimer <= wtimer + 1'b1;
        end
      end else if (start_det) begin
        st         <= S_DEV;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
        armed      <= 1'b0;
        pmask      <= '0;
      end else if (stop_det) begin
        st         <= S_IDLE;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
        if (armed) begin
          busy   <= 1'b1;
          wtimer <= '0;
          armed  <= 1'b0;
        end
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            if (st == S_RD) begin
              addr <= addr + 1'b1;
              if (sda_s) st <= S_IDLE;
            end
          end else if (bitcnt < 4'd8) begin
            bitcnt <= bitcnt + 1'b1;
            if (st != S_RD) begin
              shreg <= rx_byte[6:0];
              if (st == S_WR && bitcnt == 4'd1) armed <= 1'b0;
              if (bitcnt == 4'd7) begin
                ack_drv <= 1'b1;
                nxt     <= st;
                case (st)
                  S_DEV: begin
                    if (rx_byte[7:1] == {TYPE_ID, chip_en_i}) begin
                      nxt <= rx_byte[0] ? S_RD : S_AHI;
                    end else begin
                      st      <= S_IDLE;
                      ack_drv <= 1'b0;
                    end
                  end
                  S_AHI: begin
                    addr[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
                    nxt              <= S_ALO;
                  end
                  S_ALO: begin
                    addr[7:0] <= rx_byte;
                    nxt       <= S_WR;
                  end
                  default: begin
                    if (wp_i) begin
                      ack_drv <= 1'b0;
                    end else begin
                      pmask[addr[PAGE_W-1:0]] <= 1'b1;
                      addr[PAGE_W-1:0]        <= addr[PAGE_W-1:0] + 1'b1;
                    end
                  end
                endcase
              end
            end
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            sda_pull_o <= (st != S_RD) && ack_drv;
          end else if (bitcnt == 4'd9) begin
            bitcnt     <= '0;
            st         <= nxt;
            armed      <= (st == S_WR) && ack_drv;
            txreg      <= rd_q[6:0];
            sda_pull_o <= (nxt == S_RD) && !rd_q[7];
          end else if (st == S_RD && bitcnt != 4'd0) begin
            txreg      <= {txreg[5:0], 1'b0};
            sda_pull_o <= !txreg[6];
          end
        end
      end
    end
  end

  // R1: an idle engine never holds the line
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_pull_o);

  // R2: a pull on SDA only begins while the synchronized SCL is low
  p_pull_rise_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !$past(scl_s));

  // R4: the page part of the address stays fixed while data is accepted
  p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && $past(st) == S_WR) |-> $stable(addr[ADDR_W-1:PAGE_W]));

  // R5: the write cycle is entered only from a STOP
  p_cycle_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  // R6: silent for the whole write cycle
  p_busy_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o);
endmodule

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;
  localparam int Q   = 5;
  localparam int TWC = 600;
  localparam logic [7:0] SEL_W = 8'hAA;
  localparam logic [7:0] SEL_R = 8'hAB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       wp = 1'b0;
  logic [2:0] ce = 3'b101;
  logic       pull;
  logic       line;
  assign line = sda_m & ~pull;

  always #5 clk = ~clk;

  i2c_eeprom_target #(.WRITE_CYCLES(TWC)) u_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line),
    .chip_en_i(ce), .wp_i(wp), .sda_pull_o(pull));

  typedef struct { string tag; int val; } item_t;
  item_t exp_q[$];
  int    obs_q[$];
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;

  task automatic expect_v(input string tag, input int v);
    item_t it;
    it.tag = tag;
    it.val = v;
    exp_q.push_back(it);
  endtask

  always @(negedge clk) begin : monitor
    item_t e;
    int    a;
    if (obs_q.size() > 0) begin
      a = obs_q.pop_front();
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unmatched result actual=0x%0h expected=none", a);
      end else begin
        e = exp_q.pop_front();
        if (a != e.val) begin
          fails++;
          $display("FAIL %s actual=0x%0h expected=0x%0h", e.tag, a, e.val);
        end
      end
    end
  end

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    sda_m = b; hq();
    scl = 1'b1; hq();
    s = line; hq();
    scl = 1'b0; hq();
  endtask

  task automatic bus_start();
    if (scl) begin
      sda_m = 1'b0; hq(); scl = 1'b0; hq();
    end else begin
      sda_m = 1'b1; hq(); scl = 1'b1; hq(); sda_m = 1'b0; hq(); scl = 1'b0; hq();
    end
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl = 1'b1; hq(); sda_m = 1'b1; hq(); hq();
  endtask

  task automatic put_byte(input logic [7:0] b, input string tag, input int exp_ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    expect_v(tag, exp_ack);
    obs_q.push_back(s ? 0 : 1);
  endtask

  task automatic get_byte(input string tag, input int exp_val, input logic last);
    logic       s;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      v[i] = s;
    end
    bit_io(last, s);
    expect_v(tag, exp_val);
    obs_q.push_back(int'(v));
  endtask

  task automatic wr_head(input logic [15:0] a, input string tag);
    bus_start();
    put_byte(SEL_W, tag, 1);
    put_byte(a[15:8], tag, 1);
    put_byte(a[7:0], tag, 1);
  endtask

  task automatic rd_at(input logic [15:0] a, input string tag);
    wr_head(a, tag);
    bus_start();
    put_byte(SEL_R, tag, 1);
  endtask

  task automatic wait_cycle();
    repeat (TWC + 100) @(negedge clk);
  endtask

  initial begin : stimulus
    logic s;
    repeat (4) @(negedge clk);
    expect_v("R1 released in reset", 0);
    obs_q.push_back(int'(pull));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    bus_start(); put_byte(8'hA0, "R1 chip-enable mismatch no ack", 0); bus_stop();
    bus_start(); put_byte(8'hBA, "R1 type mismatch no ack", 0); bus_stop();

    wr_head(16'h0123, "R2 R3 header ack in 9th clock");
    put_byte(8'h5A, "R3 data ack", 1); bus_stop();
    bus_start(); put_byte(SEL_W, "R6 busy poll gets no ack", 0); bus_stop();
    wait_cycle();
    bus_start(); put_byte(SEL_W, "R6 poll after cycle acked", 1); bus_stop();

    rd_at(16'h0123, "R10 random read header");
    get_byte("R10 random read data", 8'h5A, 1'b1); bus_stop();

    wr_head(16'h0203, "R3 header"); put_byte(8'h44, "R3 data ack", 1); bus_stop(); wait_cycle();
    wr_head(16'h0200, "R4 page header");
    put_byte(8'h11, "R4 page byte", 1); put_byte(8'h22, "R4 page byte", 1);
    put_byte(8'h33, "R4 page byte", 1); bus_stop(); wait_cycle();
    bus_start(); put_byte(SEL_R, "R10 current read select", 1);
    get_byte("R8 counter after page write", 8'h44, 1'b1); bus_stop();

    rd_at(16'h0200, "R11 sequential header");
    get_byte("R11 sequential byte 0", 8'h11, 1'b0);
    get_byte("R11 sequential byte 1", 8'h22, 1'b0);
    get_byte("R11 sequential byte 2", 8'h33, 1'b0);
    get_byte("R11 sequential byte 3", 8'h44, 1'b1); bus_stop();

    wr_head(16'h003E, "R4 wrap header");
    put_byte(8'hA1, "R4 wrap byte", 1); put_byte(8'hA2, "R4 wrap byte", 1);
    put_byte(8'hA3, "R4 wrap byte", 1); put_byte(8'hA4, "R4 wrap byte", 1);
    bus_stop(); wait_cycle();
    bus_start(); put_byte(SEL_R, "R8 select", 1);
    get_byte("R8 counter after wrapped write", 8'h00, 1'b1); bus_stop();
    rd_at(16'h0020, "R4 wrap read header");
    get_byte("R4 wrapped to page offset 0", 8'hA3, 1'b0);
    get_byte("R4 wrapped to page offset 1", 8'hA4, 1'b1); bus_stop();
    rd_at(16'h003E, "R4 page end header");
    get_byte("R4 offset 30", 8'hA1, 1'b0);
    get_byte("R4 offset 31", 8'hA2, 1'b1); bus_stop();

    wr_head(16'h0FFF, "R11 header"); put_byte(8'hE1, "R11 data", 1); bus_stop(); wait_cycle();
    wr_head(16'h0000, "R11 header"); put_byte(8'hE2, "R11 data", 1); bus_stop(); wait_cycle();
    rd_at(16'h0FFF, "R11 wrap header");
    get_byte("R11 last location", 8'hE1, 1'b0);
    get_byte("R11 wrap to location 0", 8'hE2, 1'b1); bus_stop();

    wr_head(16'hF310, "R9 header upper bits set"); put_byte(8'h77, "R9 data", 1); bus_stop(); wait_cycle();
    rd_at(16'h0310, "R9 read header");
    get_byte("R9 upper address bits ignored", 8'h77, 1'b1); bus_stop();
    rd_at(16'hA310, "R9 alias header");
    get_byte("R9 alias address reads same byte", 8'h77, 1'b1); bus_stop();

    wp = 1'b1;
    wr_head(16'h0123, "R7 select and address acked under protect");
    put_byte(8'h99, "R7 data nack", 0);
    put_byte(8'h98, "R7 second data nack", 0); bus_stop();
    bus_start(); put_byte(SEL_W, "R7 no write cycle under protect", 1); bus_stop();
    wp = 1'b0;
    rd_at(16'h0123, "R7 read header");
    get_byte("R7 memory unchanged", 8'h5A, 1'b1); bus_stop();

    wr_head(16'h0123, "R5 header"); put_byte(8'h66, "R5 data ack", 1);
    bit_io(1'b1, s); bit_io(1'b0, s); bit_io(1'b1, s); bus_stop();
    bus_start(); put_byte(SEL_W, "R5 mid-byte stop starts no cycle", 1); bus_stop();
    wr_head(16'h0123, "R5 header"); put_byte(8'h67, "R5 data ack", 1);
    bus_start(); put_byte(SEL_W, "R5 repeated start starts no cycle", 1); bus_stop();
    rd_at(16'h0123, "R5 read header");
    get_byte("R5 nothing written", 8'h5A, 1'b1); bus_stop();

    wait (obs_q.size() == 0);
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL missing results actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog R1-all actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule